// File: doc/BRIEF.md
# Stack Sequencing Engine for an 8-bit CPU

This block handles the stack side of an 8-bit processor. It keeps the 8-bit stack pointer and turns each stack command into a short series of single-byte accesses on a synchronous data-memory port. The supported commands are subroutine call, interrupt entry, return, return-from-interrupt, single-byte push, single-byte pop and a pointer load. Every access lands in a fixed stack page: the upper address byte is a constant (0x01 by default) and the lower byte comes from the pointer. The stack therefore covers 0x0100 to 0x01FF.

The CPU issues a command with a one-cycle `cmd_valid` pulse while `busy` is low. It supplies the program counter, status byte and data byte that may need saving. Saving commands write at the pointer and then decrement it. Restoring commands increment the pointer and then read at the new value. Restored bytes show up on `pc_out`, `psw_out` or `pop_out`, and `done` pulses for one cycle once the last byte is finished.

The sequencer is a four-state machine:

- **IDLE** accepts commands.
  - IDLE→WRITE on a saving command.
  - IDLE→READ on a restoring command.
  - IDLE→IDLE on a pointer load, which finishes at once.
- **WRITE** sends one byte per cycle. It returns WRITE→IDLE after the last byte.
- **READ** issues one read per cycle. It moves READ→DRAIN after the last read.
- **DRAIN** captures the final byte returned by memory and goes DRAIN→IDLE.

Top module: `stack_seq`

## Requirements
- R1: A command is accepted only when `busy` is low. A `cmd_valid` pulse seen while `busy` is high causes no memory access, no `done` and no pointer change. `busy` is high from the cycle after acceptance until the engine is back in IDLE.
- R2: Every memory access uses the address {0x01, byte}. The low byte is the pointer for a write and the pointer plus one for a read.
- R3: Command encoding on `cmd_op`: 0 call, 1 interrupt entry, 2 return, 3 return-from-interrupt, 4 push, 5 pop, 6 pointer load, 7 no operation. Each write of a saving command (0, 1, 4) goes to the current pointer, and the pointer then drops by one.
- R4: Each read of a restoring command (2, 3, 5) first raises the pointer by one and then reads at the new value. Read data arrives on `mem_rdata` one cycle after the request.
- R5: A call writes PC[15:8] and then PC[7:0], leaving the pointer lower by two. `done` is high in cycle 3, counting the cycle after the accepting edge as cycle 1.
- R6: An interrupt entry writes PC[15:8], then PC[7:0], then the status byte, leaving the pointer lower by three. `done` is high in cycle 4.
- R7: A return reads the low PC byte first and the high PC byte second. `pc_out` shows {second, first}, and `done` is high in cycle 4.
- R8: A return-from-interrupt reads the status byte, then the low PC byte, then the high PC byte, updating `psw_out` and `pc_out`. `done` is high in cycle 5.
- R9: A push writes `cmd_data` and moves the pointer by one, with `done` in cycle 2. A pop moves the pointer by one and returns the byte on `pop_out`, with `done` in cycle 3.
- R10: A pointer load places `cmd_data` on `sp_out` with `done` in cycle 1. Reset does not define the pointer.
- R11: The pointer wraps modulo 256. A push at 0x00 writes 0x0100 and leaves 0xFF. A pop at 0xFF reads 0x0100 and leaves 0x00.
- R12: Op code 7 produces no access and no `done`, and leaves the pointer and the outputs unchanged. With no command, `mem_req` and `done` stay low and the result outputs hold.
- R13: Exactly one memory byte moves per cycle while in WRITE or READ, with no idle cycle between the bytes of one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_pc | input | 16 | Program counter to save |
| cmd_psw | input | 8 | Status byte to save |
| cmd_data | input | 8 | Byte to push or new pointer value |
| busy | output | 1 | Engine is sequencing a command |
| done | output | 1 | Command completed this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| sp_out | output | 8 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| psw_out | output | 8 | Restored status byte |
| pop_out | output | 8 | Byte restored by the last pop |

## Verification
Count cycles from the edge that accepts a command:

- **Accesses.** The k-th memory access of a command appears in cycle k.
- **Write completion.** For saving commands, `done` follows in the cycle after the last write.
- **Read completion.** For restoring commands there is one extra drain cycle, because memory returns read data one cycle late. `done`, the restored outputs and the final pointer appear two cycles after the last read.
- **Pointer load.** It completes in cycle 1.

At each falling edge, the bench pops one expected record per cycle from a queue built when the command was issued. It compares every output against that record, so every access, completion and result is checked in exactly the cycle it is due.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int STEP_W = 2;

    typedef enum logic [2:0] {
        OP_CALL = 3'd0,
        OP_INTR = 3'd1,
        OP_RET  = 3'd2,
        OP_RETI = 3'd3,
        OP_PUSH = 3'd4,
        OP_POP  = 3'd5,
        OP_LDSP = 3'd6,
        OP_NONE = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN
    } stk_state_e;

    typedef enum logic [1:0] {
        BK_PCH,
        BK_PCL,
        BK_PSW,
        BK_DAT
    } byte_kind_e;

    function automatic logic [STEP_W-1:0] op_len(stk_op_e op);
        case (op)
            OP_CALL, OP_RET:  op_len = 2'd2;
            OP_INTR, OP_RETI: op_len = 2'd3;
            OP_PUSH, OP_POP:  op_len = 2'd1;
            default:          op_len = 2'd0;
        endcase
    endfunction

    function automatic byte_kind_e kind_at(stk_op_e op, logic [STEP_W-1:0] step);
        kind_at = BK_DAT;
        case (op)
            OP_CALL: kind_at = (step == 2'd0) ? BK_PCH : BK_PCL;
            OP_INTR: kind_at = (step == 2'd0) ? BK_PCH : ((step == 2'd1) ? BK_PCL : BK_PSW);
            OP_RET:  kind_at = (step == 2'd0) ? BK_PCL : BK_PCH;
            OP_RETI: kind_at = (step == 2'd0) ? BK_PSW : ((step == 2'd1) ? BK_PCL : BK_PCH);
            default: kind_at = BK_DAT;
        endcase
    endfunction

    function automatic logic is_save(stk_op_e op);
        is_save = (op == OP_CALL) || (op == OP_INTR) || (op == OP_PUSH);
    endfunction

    function automatic logic is_restore(stk_op_e op);
        is_restore = (op == OP_RET) || (op == OP_RETI) || (op == OP_POP);
    endfunction
endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_up
);
    // Pointer is deliberately left out of reset: software loads it.
    always_ff @(posedge clk) begin
        if (load)     sp <= load_val;
        else if (inc) sp <= sp + 1'b1;
        else if (dec) sp <= sp - 1'b1;
    end

    assign sp_up = sp + 1'b1;

    // R3
    sp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !inc) |=> (sp == $past(sp) - 1'b1));

    // R4
    sp_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (sp == $past(sp) + 1'b1));
endmodule

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  stk_op_e    cmd_op,
    output logic       busy,
    output logic       accept,
    output logic       sp_load,
    output logic       sp_inc,
    output logic       sp_dec,
    output logic       mem_req,
    output logic       mem_we,
    output byte_kind_e cur_kind,
    output logic       cap_en,
    output byte_kind_e cap_kind,
    output logic       done
);
    stk_state_e        state, state_n;
    stk_op_e           op_q;
    logic [STEP_W-1:0] step_q, step_n;
    byte_kind_e        prev_kind_q;
    logic              done_n;
    logic              last_step;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            op_q        <= OP_NONE;
            step_q      <= '0;
            prev_kind_q <= BK_DAT;
            done        <= 1'b0;
        end else begin
            state  <= state_n;
            step_q <= step_n;
            done   <= done_n;
            if (accept)            op_q        <= cmd_op;
            if (state == ST_READ)  prev_kind_q <= cur_kind;
        end
    end

    assign last_step = (step_q == op_len(op_q) - 2'd1);
    assign cur_kind  = kind_at(op_q, step_q);
    assign busy      = (state != ST_IDLE);

    always_comb begin
        state_n  = state;
        step_n   = step_q;
        done_n   = 1'b0;
        accept   = 1'b0;
        sp_load  = 1'b0;
        sp_inc   = 1'b0;
        sp_dec   = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        cap_en   = 1'b0;
        cap_kind = prev_kind_q;
        unique case (state)
            ST_IDLE: begin
                step_n = '0;
                if (cmd_valid) begin
                    accept = 1'b1;
                    if (is_save(cmd_op))         state_n = ST_WRITE;
                    else if (is_restore(cmd_op)) state_n = ST_READ;
                    else if (cmd_op == OP_LDSP) begin
                        sp_load = 1'b1;
                        done_n  = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                sp_dec  = 1'b1;
                if (last_step) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end else begin
                    step_n = step_q + 1'b1;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                sp_inc  = 1'b1;
                cap_en  = (step_q != '0);
                if (last_step) state_n = ST_DRAIN;
                else           step_n  = step_q + 1'b1;
            end
            ST_DRAIN: begin
                cap_en  = 1'b1;
                state_n = ST_IDLE;
                done_n  = 1'b1;
            end
        endcase
    end

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(op_q));

    // R12
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(cmd_valid && cmd_op == OP_LDSP)) |=> !done);

    // R13
    read_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !last_step) |=> (state == ST_READ && mem_req));
endmodule

// File: rtl/stk_capture.sv
module stk_capture
    import stk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  byte_kind_e      cap_kind,
    input  logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] pc_out,
    output logic [DW-1:0]   psw_out,
    output logic [DW-1:0]   pop_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out  <= '0;
            psw_out <= '0;
            pop_out <= '0;
        end else if (cap_en) begin
            unique case (cap_kind)
                BK_PCH: pc_out[2*DW-1:DW] <= rdata;
                BK_PCL: pc_out[DW-1:0]    <= rdata;
                BK_PSW: psw_out           <= rdata;
                BK_DAT: pop_out           <= rdata;
            endcase
        end
    end

    // R12
    hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(pc_out) && $stable(psw_out) && $stable(pop_out)));
endmodule

// File: rtl/stack_seq.sv
module stack_seq #(
    parameter int          DW         = 8,
    parameter int          AW         = 16,
    parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [2*DW-1:0] cmd_pc,
    input  logic [DW-1:0]   cmd_psw,
    input  logic [DW-1:0]   cmd_data,
    output logic            busy,
    output logic            done,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   sp_out,
    output logic [2*DW-1:0] pc_out,
    output logic [DW-1:0]   psw_out,
    output logic [DW-1:0]   pop_out
);
    import stk_pkg::*;

    localparam int PCW = 2 * DW;

    logic       accept, sp_load, sp_inc, sp_dec, cap_en;
    byte_kind_e cur_kind, cap_kind;
    logic [DW-1:0]  sp_up;
    logic [PCW-1:0] pc_q;
    logic [DW-1:0]  psw_q, dat_q;

    stk_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (stk_op_e'(cmd_op)),
        .busy      (busy),
        .accept    (accept),
        .sp_load   (sp_load),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .cur_kind  (cur_kind),
        .cap_en    (cap_en),
        .cap_kind  (cap_kind),
        .done      (done)
    );

    stk_sp_reg #(.DW(DW)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sp_load),
        .load_val (cmd_data),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .sp       (sp_out),
        .sp_up    (sp_up)
    );

    stk_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_kind (cap_kind),
        .rdata    (mem_rdata),
        .pc_out   (pc_out),
        .psw_out  (psw_out),
        .pop_out  (pop_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            psw_q <= '0;
            dat_q <= '0;
        end else if (accept) begin
            pc_q  <= cmd_pc;
            psw_q <= cmd_psw;
            dat_q <= cmd_data;
        end
    end

    assign mem_addr = {STACK_PAGE, (mem_we ? sp_out : sp_up)};

    always_comb begin
        unique case (cur_kind)
            BK_PCH: mem_wdata = pc_q[PCW-1:DW];
            BK_PCL: mem_wdata = pc_q[DW-1:0];
            BK_PSW: mem_wdata = psw_q;
            BK_DAT: mem_wdata = dat_q;
        endcase
    end

    // R2
    page_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    // R1
    no_idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd7;
    logic [15:0] cmd_pc = '0;
    logic [7:0]  cmd_psw = '0;
    logic [7:0]  cmd_data = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, mem_rdata, sp_out, psw_out, pop_out;

    always #4 clk = ~clk;

    stack_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pc(cmd_pc), .cmd_psw(cmd_psw), .cmd_data(cmd_data),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sp_out(sp_out), .pc_out(pc_out), .psw_out(psw_out), .pop_out(pop_out)
    );

    // Stack-page memory, one cycle read latency
    logic [7:0] smem [256];
    logic [7:0] rd_q = '0;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (mem_req && mem_we)  smem[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) rd_q <= smem[mem_addr[7:0]];
    end

    typedef struct {
        bit req; bit we; bit dn; bit res;
        int addr; int wdata; int sp; int pc; int psw; int pop;
    } rec_t;

    rec_t  expq[$];
    string tagq[$];
    int    mmem [256];
    int    m_sp = 0, m_pc = 0, m_psw = 0, m_pop = 0;
    int    l_sp = 0, l_pc = 0, l_psw = 0, l_pop = 0;
    bit    sp_known = 0;
    int    total = 0, bad = 0, cyc = 0;
    bit    running = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic rec_t mk(bit req, bit we, int addr, int wdata);
        rec_t r;
        r.req = req; r.we = we; r.dn = 0; r.res = 0;
        r.addr = addr; r.wdata = wdata;
        r.sp = 0; r.pc = 0; r.psw = 0; r.pop = 0;
        return r;
    endfunction

    task automatic add(rec_t r, string tag);
        expq.push_back(r);
        tagq.push_back(tag);
    endtask

    task automatic add_done(string tag);
        rec_t r;
        r = mk(0, 0, 0, 0);
        r.dn = 1; r.res = 1;
        r.sp = m_sp; r.pc = m_pc; r.psw = m_psw; r.pop = m_pop;
        add(r, tag);
    endtask

    task automatic wr(int v, string tag);
        add(mk(1, 1, 16'h0100 + m_sp, v & 8'hff), tag);
        mmem[m_sp] = v & 8'hff;
        m_sp = (m_sp + 255) % 256;
    endtask

    function automatic int rd_next();
        m_sp = (m_sp + 1) % 256;
        return mmem[m_sp];
    endfunction

    task automatic model(int op, int pc, int psw, int d, string tag);
        int b0, b1, b2;
        case (op)
            0: begin wr(pc >> 8, tag); wr(pc, tag); add_done(tag); end
            1: begin wr(pc >> 8, tag); wr(pc, tag); wr(psw, tag); add_done(tag); end
            4: begin wr(d, tag); add_done(tag); end
            2: begin
                b0 = rd_next(); add(mk(1, 0, 16'h0100 + m_sp, 0), tag);
                b1 = rd_next(); add(mk(1, 0, 16'h0100 + m_sp, 0), tag);
                add(mk(0, 0, 0, 0), tag);
                m_pc = (b1 << 8) | b0;
                add_done(tag);
            end
            3: begin
                b0 = rd_next(); add(mk(1, 0, 16'h0100 + m_sp, 0), tag);
                b1 = rd_next(); add(mk(1, 0, 16'h0100 + m_sp, 0), tag);
                b2 = rd_next(); add(mk(1, 0, 16'h0100 + m_sp, 0), tag);
                add(mk(0, 0, 0, 0), tag);
                m_psw = b0; m_pc = (b2 << 8) | b1;
                add_done(tag);
            end
            5: begin
                b0 = rd_next(); add(mk(1, 0, 16'h0100 + m_sp, 0), tag);
                add(mk(0, 0, 0, 0), tag);
                m_pop = b0;
                add_done(tag);
            end
            6: begin m_sp = d & 8'hff; add_done(tag); end
            default: ;
        endcase
    endtask

    task automatic issue(int op, int pc, int psw, int d, string tag);
        @(negedge clk); #2;
        cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_pc = pc[15:0];
        cmd_psw = psw[7:0]; cmd_data = d[7:0];
        if (expq.size() == 0) model(op, pc, psw, d, tag);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        while (expq.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Per-cycle comparison
    always @(negedge clk) begin
        if (running) begin
            rec_t  e;
            string t;
            cyc++;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                t = tagq.pop_front();
            end else begin
                e = mk(0, 0, 0, 0);
                e.res = 1; e.sp = l_sp; e.pc = l_pc; e.psw = l_psw; e.pop = l_pop;
                t = "R12";
            end
            chk(t, "mem_req", mem_req, e.req);
            if (e.req) begin
                chk(t, "mem_we", mem_we, e.we);
                chk(t, "mem_addr R2", mem_addr, e.addr);
                if (e.we) chk(t, "mem_wdata", mem_wdata, e.wdata);
            end
            chk(t, "done", done, e.dn);
            chk("R1", "busy", busy, expq.size() > 0);
            if (e.res) begin
                if (e.dn) begin
                    l_sp = e.sp; l_pc = e.pc; l_psw = e.psw; l_pop = e.pop;
                    if (t == "R10") sp_known = 1;
                end
                if (sp_known) chk(t, "sp_out", sp_out, e.sp);
                chk(t, "pc_out", pc_out, e.pc);
                chk(t, "psw_out", psw_out, e.psw);
                chk(t, "pop_out", pop_out, e.pop);
            end
            if (cyc > 20000) begin
                bad++;
                $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
                summary();
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i] = 8'(i ^ 8'h5a);
            mmem[i] = (i ^ 8'h5a) & 8'hff;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); running = 1;
        // reset state: outputs zero, no activity
        @(negedge clk); #1;
        chk("R12", "reset pc_out", pc_out, 0);
        chk("R12", "reset done", done, 0);

        // R10 pointer load
        issue(6, 0, 0, 8'hff, "R10"); settle();
        // R5 call from 0xFF
        issue(0, 16'hd125, 0, 0, "R5"); settle();
        // R7 return
        issue(2, 0, 0, 0, "R7"); settle();
        // R6 interrupt entry
        issue(1, 16'h3c7e, 8'h96, 0, "R6"); settle();
        // R8 return from interrupt
        issue(3, 0, 0, 0, "R8"); settle();
        // R9 push and pop
        issue(4, 0, 0, 8'ha5, "R9"); settle();
        issue(4, 0, 0, 8'h3b, "R9"); settle();
        issue(5, 0, 0, 0, "R9"); settle();
        issue(5, 0, 0, 0, "R9"); settle();
        // R1 command while busy is ignored
        issue(0, 16'h1234, 0, 0, "R1");
        issue(6, 0, 0, 8'h33, "R1");
        issue(5, 0, 0, 0, "R1");
        settle();
        issue(2, 0, 0, 0, "R7"); settle();
        // R12 no-op code
        issue(7, 16'hffff, 8'hff, 8'h10, "R12"); settle();
        // R11 wrap on push at 0x00 and pop at 0xFF
        issue(6, 0, 0, 8'h00, "R10"); settle();
        issue(4, 0, 0, 8'hc4, "R11"); settle();
        issue(5, 0, 0, 0, "R11"); settle();
        issue(6, 0, 0, 8'hff, "R10"); settle();
        issue(5, 0, 0, 0, "R11"); settle();
        // R13 back-to-back commands and a mid-stack interrupt frame
        issue(6, 0, 0, 8'h80, "R10");
        issue(1, 16'hbeef, 8'h42, 0, "R13"); settle();
        issue(3, 0, 0, 0, "R13"); settle();
        issue(6, 0, 0, 8'h01, "R10"); settle();
        issue(0, 16'h0a0b, 0, 0, "R11"); settle();
        issue(2, 0, 0, 0, "R11"); settle();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule